// File: doc/BRIEF.md
# Pipelined Unsigned-by-Signed Multiplier

This block forms the exact two's-complement product of an unsigned operand and a signed operand, 18 bits each, and returns a 36-bit signed result. It is written so that the multiply itself is a plain signed 18x18 operation. The unsigned operand is never widened with a leading zero, so the product fits one hard multiplier of that size and does not spill into a wider one.

The unsigned operand goes into the signed multiply bit for bit, as if it were signed. When its top bit is set, that reading is low by 2^18 times the signed operand. The second pipeline stage corrects this by adding the signed operand into the upper 18 bits of the raw product, modulo 2^36. The first stage registers the operands and the raw product. The second stage registers the corrected result.

A new operand pair can be presented on every cycle. Each valid input comes out two clock cycles later together with an output-valid strobe.

Top module: `umul_us_pipe`

## Requirements
- R1: For every accepted pair, `product` equals the zero-extended value of `a_u` times the sign-extended value of `b_s`, as a 36-bit two's-complement number. The correction never alters `product[17:0]`.
- R2: A pair presented with `in_valid` high at a rising edge appears on `product` with `out_valid` high after exactly two rising edges. Pairs presented on consecutive cycles come out on consecutive cycles in the same order.
- R3: `out_valid` is low in every cycle whose input two edges earlier had `in_valid` low, so gaps in the input stream show up unchanged at the output.
- R4: While `rst_n` is low, and after it is released until a new valid pair has passed through, `out_valid` stays low. Pairs in flight when reset is asserted are discarded.
- R5: The result is exact at these corners: `a_u` = 262143 times `b_s` = -131072 gives -34359607296; `a_u` = 131072 times `b_s` = 131071 gives 17179738112; either operand zero gives 0.
- R6: When bit 17 of `a_u` is 0, no correction is applied, and the result equals the plain signed product.
- R7: While no new result is produced, `product` holds the last result it delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Qualifies `a_u` and `b_s` in this cycle |
| a_u | input | 18 | Unsigned operand |
| b_s | input | 18 | Signed two's-complement operand |
| out_valid | output | 1 | `product` carries a new result in this cycle |
| product | output | 36 | Signed two's-complement product |

## Verification
A missing or misplaced correction shows at the ports two cycles after any pair whose unsigned top bit is set. The upper half of the product is then off by exactly the signed operand, while the lower half stays right, so corner pairs and random pairs with that bit set expose it at once. A valid flag that is lost, stuck or mis-timed shifts the output strobe against the bench's two-edge model. That shows up on the first cycle of a gap, on a back-to-back burst, or just after a reset taken mid-stream. A data register that loads without its enable is caught on the first idle cycle, because the held result changes.

// File: rtl/umul_pkg.sv
package umul_pkg;
  // Default operand widths; the product width is derived in each module.
  localparam int unsigned UMUL_A_W = 18;
  localparam int unsigned UMUL_B_W = 18;
  localparam int unsigned UMUL_RST_STAGES = 2;
endpackage

// File: rtl/umul_rst_sync.sv
module umul_rst_sync #(
  parameter int unsigned STAGES = umul_pkg::UMUL_RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

  initial begin
    a_stages_ok: assert (STAGES >= 2)
      else $error("reset synchronizer needs two or more stages");
  end
endmodule

// File: rtl/umul_core_stage.sv
module umul_core_stage #(
  parameter int unsigned A_W = umul_pkg::UMUL_A_W,
  parameter int unsigned B_W = umul_pkg::UMUL_B_W,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [A_W-1:0]        a_u,
  input  logic signed [B_W-1:0] b_s,
  output logic                  s1_valid,
  output logic                  s1_msb,
  output logic signed [B_W-1:0] s1_b,
  output logic signed [P_W-1:0] s1_raw
);
  logic                  valid_d;
  logic signed [P_W-1:0] raw_d;
  logic                  load_en;

  // Same-width signed multiply: the unsigned operand is reinterpreted.
  always_comb begin
    load_en = in_valid;
    valid_d = in_valid;
    raw_d   = $signed(a_u) * b_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      s1_msb <= a_u[A_W-1];
      s1_b   <= b_s;
      s1_raw <= raw_d;
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !s1_valid);
  p_msb_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (s1_msb == $past(a_u[A_W-1])));
endmodule

// File: rtl/umul_fix_stage.sv
module umul_fix_stage #(
  parameter int unsigned A_W = umul_pkg::UMUL_A_W,
  parameter int unsigned B_W = umul_pkg::UMUL_B_W,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s1_valid,
  input  logic                  s1_msb,
  input  logic signed [B_W-1:0] s1_b,
  input  logic signed [P_W-1:0] s1_raw,
  output logic                  out_valid,
  output logic signed [P_W-1:0] product
);
  logic signed [B_W-1:0] upper_fix;
  logic signed [P_W-1:0] product_d;
  logic                  valid_d;

  // Add the signed operand into the upper half when the unsigned MSB is set.
  always_comb begin
    upper_fix = s1_msb ? s1_b : '0;
    product_d = {s1_raw[P_W-1:A_W] + upper_fix, s1_raw[A_W-1:0]};
    valid_d   = s1_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) product <= product_d;
  end

  p_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1_valid && out_valid) |=> $stable(product));
  p_low_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (product[A_W-1:0] == $past(s1_raw[A_W-1:0])));
  p_no_fix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_msb) |=> (product == $past(s1_raw)));
endmodule

// File: rtl/umul_us_pipe.sv
module umul_us_pipe #(
  parameter int unsigned A_W = umul_pkg::UMUL_A_W,
  parameter int unsigned B_W = umul_pkg::UMUL_B_W,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [A_W-1:0]        a_u,
  input  logic signed [B_W-1:0] b_s,
  output logic                  out_valid,
  output logic signed [P_W-1:0] product
);
  logic                  rst_sync_n;
  logic                  s1_valid;
  logic                  s1_msb;
  logic signed [B_W-1:0] s1_b;
  logic signed [P_W-1:0] s1_raw;

  umul_rst_sync #(.STAGES(umul_pkg::UMUL_RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  umul_core_stage #(.A_W(A_W), .B_W(B_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid),
    .a_u(a_u), .b_s(b_s),
    .s1_valid(s1_valid), .s1_msb(s1_msb), .s1_b(s1_b), .s1_raw(s1_raw)
  );

  umul_fix_stage #(.A_W(A_W), .B_W(B_W)) u_fix (
    .clk(clk), .rst_n(rst_sync_n),
    .s1_valid(s1_valid), .s1_msb(s1_msb), .s1_b(s1_b), .s1_raw(s1_raw),
    .out_valid(out_valid), .product(product)
  );

  p_reset_quiet_r4: assert property (@(posedge clk)
    !rst_sync_n |-> !out_valid);
  p_stage_chain_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $past(s1_valid));
endmodule

// File: tb/umul_us_pipe_test.sv
`timescale 1ns/1ps
module umul_us_pipe_test;
  localparam int A_W = 18;
  localparam int B_W = 18;
  localparam int P_W = A_W + B_W;

  typedef struct { longint val; string tag; } exp_t;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid = 1'b0;
  logic [A_W-1:0]        a_u = '0;
  logic signed [B_W-1:0] b_s = '0;
  logic                  out_valid;
  logic signed [P_W-1:0] product;

  int   n_checks = 0;
  int   n_fail = 0;
  exp_t q[$];
  logic cur_v;
  logic vd1 = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  umul_us_pipe uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_u(a_u), .b_s(b_s), .out_valid(out_valid), .product(product)
  );

  function automatic longint ref_mul(logic [A_W-1:0] a, logic signed [B_W-1:0] b);
    longint ua;
    longint sb;
    ua = longint'({46'd0, a});
    sb = longint'(b);
    return ua * sb;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Per-cycle monitor: strobe timing and result values.
  always @(posedge clk) begin
    cur_v = in_valid;
    if (!rst_n) begin vd1 = 1'b0; cur_v = 1'b0; end
    #1;
    if (!done) begin
      check("R2/R3 out_valid timing", longint'(out_valid), longint'(vd1));
      if (out_valid) begin
        if (q.size() == 0) begin
          check("R2 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.tag, longint'(product), e.val);
        end
      end
    end
    vd1 = cur_v;
  end

  task automatic put(logic [A_W-1:0] a, logic signed [B_W-1:0] b, string tag);
    exp_t e;
    @(negedge clk);
    a_u = a; b_s = b; in_valid = 1'b1;
    e.val = ref_mul(a, b); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a_u = A_W'($urandom);
      b_s = B_W'($urandom);
    end
  endtask

  task automatic t_reset_state();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R4 out_valid in reset", longint'(out_valid), 0);
    end
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic t_corners();
    put(18'h3FFFF, -18'sd131072, "R5 max by min");
    put(18'h20000, 18'sd131071, "R5 msb by max");
    put(18'h00000, -18'sd5, "R5 zero unsigned");
    put(18'h2A5A5, 18'sd0, "R5 zero signed");
    put(18'h3FFFF, -18'sd1, "R5 max by minus one");
    idle(3);
    check("R5 corner literal", ref_mul(18'h3FFFF, -18'sd131072), -64'sd34359607296);
    check("R5 corner literal", ref_mul(18'h20000, 18'sd131071), 64'sd17179738112);
  endtask

  task automatic t_msb_clear();
    for (int i = 0; i < 20; i++)
      put({1'b0, 17'($urandom)}, B_W'($urandom), "R6 msb clear");
    idle(3);
  endtask

  task automatic t_msb_set();
    for (int i = 0; i < 20; i++)
      put({1'b1, 17'($urandom)}, B_W'($urandom), "R1 msb set");
    idle(3);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 300; i++)
      put(A_W'($urandom), B_W'($urandom), "R1 R2 stream");
    idle(3);
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 40; i++) begin
      put(A_W'($urandom), B_W'($urandom), "R3 gapped");
      if (i % 3 != 0) idle(i % 4);
    end
    idle(3);
  endtask

  task automatic t_hold();
    longint last;
    put(18'h3ABCD, -18'sd77, "R7 held value");
    last = ref_mul(18'h3ABCD, -18'sd77);
    idle(3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      a_u = A_W'($urandom); b_s = B_W'($urandom);
      check("R7 product held", longint'(product), last);
      check("R7 no strobe", longint'(out_valid), 0);
    end
  endtask

  task automatic t_mid_reset();
    put(18'h12345, 18'sd999, "R4 dropped");
    put(18'h23456, -18'sd999, "R4 dropped");
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    q.delete();
    #1;
    check("R4 strobe cleared at reset", longint'(out_valid), 0);
    idle(2);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      idle(1);
      check("R4 quiet after reset", longint'(out_valid), 0);
    end
    put(18'h00007, 18'sd6, "R4 first after reset");
    idle(4);
    check("R4 queue drained", longint'(q.size()), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_corners();
    t_msb_clear();
    t_msb_set();
    t_back_to_back();
    t_gaps();
    t_hold();
    t_mid_reset();
    check("R2 all results seen", longint'(q.size()), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule